// File: doc/BRIEF.md
# Pin Edge Pending Capture Unit

This unit watches a bank of input pins and records transitions on them. Each pin first passes through a two-stage synchroniser. A per-pin polarity bit selects whether a rising or a falling transition counts. When the selected transition is seen, a sticky pending flag is set for that pin. The flag stays set until software overwrites it.

Software reaches the flags only through an exchange port. In one cycle the port returns the flags as they stood and loads a new value. Writing zero is the normal way to acknowledge every event at once. Flags latch whether or not the pin's interrupt is enabled. A per-pin disable bit gates only the contribution of that pin to the interrupt request.

The request is merged with an external timer rollover into one shared vector request. Service code must therefore read the flags to tell the two causes apart.

Top module: `pin_edge_pend`

## Requirements
- R1: While reset is low, on the next clock all pending flags are 0, and irq_o is 0 once reset has been applied.
- R2: With edge_fall_i[n]=0, a 0-to-1 change on pin_i[n] sets pend_o[n]. The flag is visible after the third rising clock edge following the pin change and not after the second.
- R3: With edge_fall_i[n]=1, only a 1-to-0 change on pin_i[n] sets pend_o[n]. A change in the other direction leaves the flag at 0.
- R4: A set flag stays 1 through further edges of either direction until an exchange writes it.
- R5: When xchg_en_i=1, xchg_rdata_o shows the flags held before the write in that same cycle. After the clock edge, pend_o equals xchg_wdata_i (writing 0 clears all flags).
- R6: A selected edge detected in the same cycle as an exchange write sets its flag, whatever bit value is written for that pin.
- R7: Flags latch regardless of irq_off_i. irq_off_i[n]=1 only removes pin n from the request.
- R8: irq_o is 1 exactly when some n has pend_o[n]=1 and irq_off_i[n]=0, with no added cycle of delay.
- R9: vec_req_o is irq_o OR timer_roll_i, so a timer rollover raises the shared request even with no pending flag.
- R10: The synchroniser resets to 0. A pin held high through reset, with edge_fall_i=0, is therefore seen as a rising edge three clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | W | Asynchronous pin inputs |
| edge_fall_i | input | W | Per pin: 1 selects falling edges, 0 selects rising edges |
| irq_off_i | input | W | Per pin: 0 lets the flag raise irq_o, 1 blocks it |
| xchg_en_i | input | 1 | Exchange strobe for the pending flags |
| xchg_wdata_i | input | W | Value loaded into the flags on exchange |
| xchg_rdata_o | output | W | Flags before the write in the current cycle |
| pend_o | output | W | Current pending flags |
| irq_o | output | 1 | OR of enabled pending flags |
| timer_roll_i | input | 1 | Timer rollover request sharing the vector |
| vec_req_o | output | 1 | Combined request to the single vector |

## Verification
A stale or wrongly set flag shows directly on pend_o and xchg_rdata_o. It shows on irq_o in the same cycle, so a corrupted flag is visible one clock after the edge that caused it. A wrong edge-polarity decode or a wrong synchroniser depth moves the flag by at least a cycle against the three-clock latency. The bench samples the flags exactly at the second and third clocks to catch that. A wrong priority between a write and a coincident edge loses a flag, and the bench sees that one clock after the exchange.

// File: rtl/pin_edge_pend_pkg.sv
// Shared definitions for the pin edge pending unit.
// Assumes: polarity encoding 1 = falling, 0 = rising.
package pin_edge_pend_pkg;

    localparam int unsigned PIN_W_DEF = 8;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;

    // True when the chosen transition is seen between two samples.
    function automatic logic edge_seen(input logic prev_v, input logic cur_v,
                                       input edge_pol_e pol);
        logic hit;
        if (pol == EDGE_FALL) hit = prev_v & ~cur_v;
        else                  hit = ~prev_v & cur_v;
        return hit;
    endfunction

endpackage

// File: rtl/pin_edge_pend_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes: each bit is independent; every stage resets to 0.
module pin_edge_pend_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [W-1:0] stage_q [STAGES];

    // Shift the input through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[LAST];
endmodule

// File: rtl/pin_edge_pend_edge.sv
// Per-pin edge detector with selectable polarity.
// Assumes: input is already synchronous; history register resets to 0.
module pin_edge_pend_edge
    import pin_edge_pend_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] fall_sel_i,
    output logic [W-1:0] hit_o
);
    logic [W-1:0] prev_q;

    // Remember the last synchronised sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur_i;
    end

    for (genvar g = 0; g < W; g++) begin : g_det
        assign hit_o[g] = edge_seen(prev_q[g], cur_i[g], edge_pol_e'(fall_sel_i[g]));
    end
endmodule

// File: rtl/pin_edge_pend_store.sv
// Sticky pending flags with atomic exchange access.
// Assumes: a detected edge outranks the value being written.
module pin_edge_pend_store #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hit_i,
    input  logic         xchg_en_i,
    input  logic [W-1:0] xchg_wdata_i,
    output logic [W-1:0] xchg_rdata_o,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] pend_q;
    logic [W-1:0] base;
    logic [W-1:0] pend_d;

    // Pick the written value or the held flags, then OR in new edges.
    always_comb begin
        base   = xchg_en_i ? xchg_wdata_i : pend_q;
        pend_d = base | hit_i;
    end

    // Hold the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign xchg_rdata_o = pend_q;
    assign pend_o       = pend_q;
endmodule

// File: rtl/pin_edge_pend_req.sv
// Request generation: enabled-flag OR and the shared vector merge.
// Assumes: disable bit 1 blocks a pin; timer request is already synchronous.
module pin_edge_pend_req #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] pend_i,
    input  logic [W-1:0] off_i,
    input  logic         timer_roll_i,
    output logic         irq_o,
    output logic         vec_req_o
);
    logic [W-1:0] live;

    // Mask flags, reduce, then merge with the timer source.
    always_comb begin
        live      = pend_i & ~off_i;
        irq_o     = |live;
        vec_req_o = irq_o | timer_roll_i;
    end
endmodule

// File: rtl/pin_edge_pend.sv
// Top: synchroniser, edge detector, pending store and request logic.
// Assumes: all control inputs are synchronous to clk; pins are not.
module pin_edge_pend
    import pin_edge_pend_pkg::*;
#(
    parameter int unsigned W           = PIN_W_DEF,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] edge_fall_i,
    input  logic [W-1:0] irq_off_i,
    input  logic         xchg_en_i,
    input  logic [W-1:0] xchg_wdata_i,
    output logic [W-1:0] xchg_rdata_o,
    output logic [W-1:0] pend_o,
    output logic         irq_o,
    input  logic         timer_roll_i,
    output logic         vec_req_o
);
    logic [W-1:0] pin_s;
    logic [W-1:0] hit;

    pin_edge_pend_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_s)
    );

    pin_edge_pend_edge #(.W(W)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_i      (pin_s),
        .fall_sel_i (edge_fall_i),
        .hit_o      (hit)
    );

    pin_edge_pend_store #(.W(W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_i        (hit),
        .xchg_en_i    (xchg_en_i),
        .xchg_wdata_i (xchg_wdata_i),
        .xchg_rdata_o (xchg_rdata_o),
        .pend_o       (pend_o)
    );

    pin_edge_pend_req #(.W(W)) u_req (
        .pend_i       (pend_o),
        .off_i        (irq_off_i),
        .timer_roll_i (timer_roll_i),
        .irq_o        (irq_o),
        .vec_req_o    (vec_req_o)
    );
endmodule

// File: rtl/pin_edge_pend_chk.sv
// Property checker for pin_edge_pend, attached by bind.
// Assumes: it only observes top-level ports.
module pin_edge_pend_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] irq_off_i,
    input logic         xchg_en_i,
    input logic [W-1:0] xchg_wdata_i,
    input logic [W-1:0] pend_o,
    input logic         irq_o,
    input logic         timer_roll_i,
    input logic         vec_req_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (pend_o == '0)); // R1

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !xchg_en_i |=> ((pend_o & $past(pend_o)) == $past(pend_o))); // R4

    AST_XCHG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_en_i |=> ((pend_o & $past(xchg_wdata_i)) == $past(xchg_wdata_i))); // R5

    AST_IRQ_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((pend_o & ~irq_off_i) != '0)); // R8

    AST_TIMER_SHARES: assert property (@(posedge clk) disable iff (!rst_n)
        timer_roll_i |-> vec_req_o); // R9
endmodule

bind pin_edge_pend pin_edge_pend_chk #(.W(W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_off_i    (irq_off_i),
    .xchg_en_i    (xchg_en_i),
    .xchg_wdata_i (xchg_wdata_i),
    .pend_o       (pend_o),
    .irq_o        (irq_o),
    .timer_roll_i (timer_roll_i),
    .vec_req_o    (vec_req_o)
);

// File: tb/pin_edge_pend_tb_top.sv
module pin_edge_pend_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = '0;
    logic [7:0] edge_fall_i = '0;
    logic [7:0] irq_off_i = 8'hFF;
    logic       xchg_en_i = 1'b0;
    logic [7:0] xchg_wdata_i = '0;
    logic [7:0] xchg_rdata_o;
    logic [7:0] pend_o;
    logic       irq_o;
    logic       timer_roll_i = 1'b0;
    logic       vec_req_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pin_edge_pend dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .edge_fall_i(edge_fall_i),
        .irq_off_i(irq_off_i), .xchg_en_i(xchg_en_i), .xchg_wdata_i(xchg_wdata_i),
        .xchg_rdata_o(xchg_rdata_o), .pend_o(pend_o), .irq_o(irq_o),
        .timer_roll_i(timer_roll_i), .vec_req_o(vec_req_o)
    );

    typedef struct packed {
        logic       clr;
        logic [7:0] rd;
        logic [7:0] pin;
        logic [7:0] sel;
        logic [7:0] off;
        logic [7:0] pend;
        logic       irq;
    } row_t;

    // clr, rd-before-clear, pin, falling-select, irq-off, expected flags, expected irq
    localparam row_t ROWS [8] = '{
        '{1'b0, 8'h00, 8'h0F, 8'h00, 8'hFF, 8'h0F, 1'b0},
        '{1'b0, 8'h00, 8'h0F, 8'h00, 8'hFE, 8'h0F, 1'b1},
        '{1'b1, 8'h0F, 8'h00, 8'h00, 8'hFE, 8'h00, 1'b0},
        '{1'b0, 8'h00, 8'hF0, 8'hFF, 8'h0F, 8'h00, 1'b0},
        '{1'b0, 8'h00, 8'h00, 8'hFF, 8'h0F, 8'hF0, 1'b1},
        '{1'b0, 8'h00, 8'hF0, 8'hFF, 8'h0F, 8'hF0, 1'b1},
        '{1'b0, 8'h00, 8'h00, 8'hFF, 8'h0F, 8'hF0, 1'b1},
        '{1'b1, 8'hF0, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0}
    };

    function automatic string row_tag(input int i);
        case (i)
            0: return "R2/R7";
            1: return "R8";
            2: return "R5";
            3: return "R3";
            4: return "R3";
            5: return "R4";
            6: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic exchange(input logic [7:0] wv, input logic [7:0] exp_rd, input string tag);
        @(negedge clk);
        xchg_en_i    = 1'b1;
        xchg_wdata_i = wv;
        #1 chk(tag, xchg_rdata_o, exp_rd);
        @(posedge clk);
        @(negedge clk);
        xchg_en_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 flags", pend_o, 8'h00);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            if (ROWS[i].clr) exchange(8'h00, ROWS[i].rd, {row_tag(i), " rd"});
            @(negedge clk);
            pin_i       = ROWS[i].pin;
            edge_fall_i = ROWS[i].sel;
            irq_off_i   = ROWS[i].off;
            repeat (3) @(posedge clk);
            @(negedge clk);
            #1;
            chk({row_tag(i), " flags"}, pend_o, ROWS[i].pend);
            chk({row_tag(i), " irq"}, {7'b0, irq_o}, {7'b0, ROWS[i].irq});
        end

        // R2 latency: absent after two clocks, present after three
        @(negedge clk);
        edge_fall_i = 8'h00;
        irq_off_i   = 8'hFF;
        pin_i       = 8'h02;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R2 early", pend_o, 8'h00);
        @(posedge clk);
        @(negedge clk);
        chk("R2 late", pend_o, 8'h02);

        // R5 load of arbitrary values, reading the prior contents
        exchange(8'hA5, 8'h02, "R5 rd1");
        chk("R5 load1", pend_o, 8'hA5);
        exchange(8'h3C, 8'hA5, "R5 rd2");
        chk("R5 load2", pend_o, 8'h3C);
        exchange(8'h00, 8'h3C, "R5 rd3");

        // R6 edge coinciding with a clearing write
        @(negedge clk);
        pin_i = 8'h82;
        repeat (2) @(posedge clk);
        @(negedge clk);
        xchg_en_i    = 1'b1;
        xchg_wdata_i = 8'h00;
        @(posedge clk);
        @(negedge clk);
        xchg_en_i = 1'b0;
        chk("R6 edge wins", pend_o, 8'h80);
        exchange(8'h00, 8'h80, "R6 rd");

        // R9 shared vector
        @(negedge clk);
        irq_off_i    = 8'hFF;
        timer_roll_i = 1'b1;
        #1 chk("R9 timer only", {6'b0, irq_o, vec_req_o}, 8'h01);
        timer_roll_i = 1'b0;
        #1 chk("R9 idle", {7'b0, vec_req_o}, 8'h00);
        exchange(8'h10, 8'h00, "R9 rd");
        irq_off_i = 8'hEF;
        #1 chk("R9 pin only", {6'b0, irq_o, vec_req_o}, 8'h03);
        irq_off_i = 8'hFF;
        #1 chk("R8 blocked", {7'b0, irq_o}, 8'h00);

        // R10 pin high through reset reads as rising edge
        @(negedge clk);
        rst_n       = 1'b0;
        pin_i       = 8'h01;
        edge_fall_i = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 re-reset", pend_o, 8'h00);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset edge", pend_o, 8'h01);

        report();
    end
endmodule